// File: doc/BRIEF.md
# Test pulse pattern sequencer

This block produces a repeating stimulus pattern on up to 32 parallel test-pulse lines. These lines exercise the channels of a time-to-digital converter board, so the block can be used to check timing resolution and missing hits on that board. Each pattern opens with a request/acknowledge handshake toward a trigger distributor. A one-cycle time-stamp reset follows. Three phases of channel pulses then play:
- phase A: each enabled channel is pulsed on its own, with a long pause between pulses;
- phase B: all enabled channels are pulsed together;
- phase C: each enabled channel is pulsed on its own again, with short spacing.

An independent timer issues two readout triggers at programmed delays after the time-stamp reset, so that the readout windows can cover the whole pattern.

The pattern repeats for as long as the enable input stays high. If enable drops, the pattern in progress runs to its end, so no pulse is ever cut short. All durations are counts of clock cycles. With the nominal 2.5 ns clock, a 20 ns pulse is 8 cycles, the 10 ns floor is 4 cycles, and the 12.8 µs pause is 5120 cycles. If the acknowledge does not arrive within a programmed number of cycles, an error flag is set and the block goes back to idle.

Top module: `tpat_sequencer`

## Requirements
- R1: While reset is asserted, every pulse line is low, and so are sync_req_o, ts_rst_o, trig_o and err_o.
- R2: When en_i is high in idle, sync_req_o goes high and stays high until ack_i is sampled high. The next cycle is the only cycle of the pattern in which ts_rst_o is high, and sync_req_o is low in that cycle.
- R3: If ack_i is not seen within max(cfg_ack_to_i,1) cycles, sync_req_o falls after exactly that many high cycles, err_o is set, and the block returns to idle. err_o clears when a later acknowledge is accepted.
- R4: Phase A starts in the cycle after ts_rst_o. It pulses each enabled channel alone, in ascending index order, with a new pulse starting every L+GA cycles.
- R5: Phase B drives all enabled channels together for L cycles. It starts L+GA cycles after the last phase A pulse starts.
- R6: Phase C pulses each enabled channel alone, in ascending order, with a new pulse starting every L+GC cycles. It starts L+GA cycles after phase B starts.
- R7: L = max(cfg_pulse_len_i, MIN_PULSE_CYC), with MIN_PULSE_CYC = 4. GA = max(cfg_gap_a_i,1) and GC = max(cfg_gap_c_i,1). Every pulse is high for exactly L cycles.
- R8: If ts_rst_o is high in cycle k, trig_o has single-cycle pulses in cycles k+1+D1 and k+1+D1+max(D2,2), and no others, where D1 = cfg_trig_dly1_i and D2 = cfg_trig_dly2_i.
- R9: The channel mask, L, GA and GC are captured when the acknowledge is accepted. A channel whose mask bit is 0 never pulses. With an empty mask, no pulses are produced, but ts_rst_o and both triggers still occur.
- R10: With en_i held high, the next sync_req_o rises 2 cycles after the later of two cycles: the last cycle of the final phase-C gap (cycle k if the mask is empty) and the second trigger.
- R11: Clearing en_i during a pattern lets that pattern finish completely (all pulses and both triggers) and then leaves sync_req_o low.
- R12: ack_i sampled while sync_req_o is low has no effect. It produces no time-stamp reset, no pulse, no request, and no change to err_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Run patterns while high |
| ack_i | input | 1 | Acknowledge from trigger distributor |
| cfg_mask_i | input | NCH | Enabled channel mask |
| cfg_pulse_len_i | input | CW | Pulse length in cycles |
| cfg_gap_a_i | input | CW | Pause after each phase A and B pulse |
| cfg_gap_c_i | input | CW | Pause after each phase C pulse |
| cfg_trig_dly1_i | input | CW | First trigger delay |
| cfg_trig_dly2_i | input | CW | Spacing of second trigger |
| cfg_ack_to_i | input | CW | Acknowledge timeout in cycles |
| pulse_o | output | NCH | Test pulse lines |
| sync_req_o | output | 1 | Handshake request |
| ts_rst_o | output | 1 | Time-stamp reset pulse |
| trig_o | output | 1 | Readout trigger pulses |
| err_o | output | 1 | Acknowledge timeout flag |

## Verification
The bench builds the block with its default parameters: NCH = 32, CW = 16 and MIN_PULSE_CYC = 4. It sets the cycle counts through the configuration ports to small values, so each pattern completes in a few hundred cycles. Because all 32 lines are present, a full mask, a mask with only the two end bits set, a single channel and an empty mask can all be tried. Zero gaps and short pulse lengths reach the clamping floors. Trigger delays that place the second trigger both inside and past the pulse phases exercise both cases of the repeat spacing.

// File: rtl/tpat_pkg.sv
`timescale 1ns/1ps
package tpat_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_SYNC,
    ST_TSRST,
    ST_A_PLS,
    ST_A_GAP,
    ST_B_PLS,
    ST_B_GAP,
    ST_C_PLS,
    ST_C_GAP,
    ST_DRAIN
  } tpat_state_e;

  // Smallest spacing between the two readout triggers, in cycles
  localparam int unsigned TRIG_MIN_SPACE = 2;

endpackage

// File: rtl/tpat_down_cnt.sv
`timescale 1ns/1ps
module tpat_down_cnt #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld_i,
  input  logic [CW-1:0] ld_val_i,
  output logic          zero_o
);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  assign cnt_en = ld_i || (cnt_q != '0);

  always_comb begin
    cnt_d = cnt_q;
    if (ld_i) begin
      cnt_d = ld_val_i;
    end else if (cnt_q != '0) begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign zero_o = (cnt_q == '0);

endmodule

// File: rtl/tpat_next_chan.sv
`timescale 1ns/1ps
module tpat_next_chan #(
  parameter int NCH = 32,
  parameter int IW  = 5
) (
  input  logic [NCH-1:0] mask_i,
  input  logic [IW-1:0]  cur_i,
  output logic [IW-1:0]  first_idx_o,
  output logic           first_vld_o,
  output logic [IW-1:0]  next_idx_o,
  output logic           next_vld_o
);

  // Scan from the top so the lowest matching index is kept last
  always_comb begin
    first_idx_o = '0;
    first_vld_o = 1'b0;
    next_idx_o  = '0;
    next_vld_o  = 1'b0;
    for (int i = NCH - 1; i >= 0; i--) begin
      if (mask_i[i]) begin
        first_idx_o = IW'(i);
        first_vld_o = 1'b1;
        if (i > int'(cur_i)) begin
          next_idx_o = IW'(i);
          next_vld_o = 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/tpat_trig_timer.sv
`timescale 1ns/1ps
module tpat_trig_timer
  import tpat_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic [CW-1:0] dly1_i,
  input  logic [CW-1:0] dly2_i,
  output logic          trig_o,
  output logic          done_o
);

  localparam int TW = CW + 1;

  logic [CW-1:0] space;
  logic [TW-1:0] t_q, t_d, end_q, end_d, first_q, first_d;
  logic          run_q, run_d, done_q, done_d;
  logic          upd_en;

  assign space   = (dly2_i < CW'(TRIG_MIN_SPACE)) ? CW'(TRIG_MIN_SPACE) : dly2_i;
  assign upd_en  = start_i || run_q;

  always_comb begin
    t_d     = t_q;
    end_d   = end_q;
    first_d = first_q;
    run_d   = run_q;
    done_d  = done_q;
    if (start_i) begin
      t_d     = '0;
      first_d = {1'b0, dly1_i};
      end_d   = {1'b0, dly1_i} + {1'b0, space};
      run_d   = 1'b1;
      done_d  = 1'b0;
    end else if (run_q) begin
      t_d = t_q + 1'b1;
      if (t_q == end_q) begin
        run_d  = 1'b0;
        done_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      t_q     <= '0;
      end_q   <= '0;
      first_q <= '0;
      run_q   <= 1'b0;
      done_q  <= 1'b0;
    end else if (upd_en) begin
      t_q     <= t_d;
      end_q   <= end_d;
      first_q <= first_d;
      run_q   <= run_d;
      done_q  <= done_d;
    end
  end

  assign trig_o = run_q && ((t_q == first_q) || (t_q == end_q));
  assign done_o = done_q;

endmodule

// File: rtl/tpat_sequencer.sv
`timescale 1ns/1ps
module tpat_sequencer
  import tpat_pkg::*;
#(
  parameter int NCH           = 32,
  parameter int CW            = 16,
  parameter int MIN_PULSE_CYC = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           en_i,
  input  logic           ack_i,
  input  logic [NCH-1:0] cfg_mask_i,
  input  logic [CW-1:0]  cfg_pulse_len_i,
  input  logic [CW-1:0]  cfg_gap_a_i,
  input  logic [CW-1:0]  cfg_gap_c_i,
  input  logic [CW-1:0]  cfg_trig_dly1_i,
  input  logic [CW-1:0]  cfg_trig_dly2_i,
  input  logic [CW-1:0]  cfg_ack_to_i,
  output logic [NCH-1:0] pulse_o,
  output logic           sync_req_o,
  output logic           ts_rst_o,
  output logic           trig_o,
  output logic           err_o
);

  localparam int IW = (NCH > 1) ? $clog2(NCH) : 1;

  // Reset: asserted at once, released after two clock edges
  logic rst_meta_q, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  tpat_state_e   state_q, state_d;
  logic [NCH-1:0] mask_q;
  logic [CW-1:0]  len_q, gap_a_q, gap_c_q;
  logic [IW-1:0]  ch_q, ch_d;
  logic           err_q, err_d;
  logic           cfg_en, ch_en;

  logic [CW-1:0]  len_eff, gap_a_eff, gap_c_eff, to_eff;
  logic           ld;
  logic [CW-1:0]  ld_val;
  logic           cnt_zero;
  logic [IW-1:0]  first_idx, next_idx;
  logic           first_vld, next_vld;
  logic           trig_done;

  assign len_eff   = (cfg_pulse_len_i < CW'(MIN_PULSE_CYC)) ? CW'(MIN_PULSE_CYC) : cfg_pulse_len_i;
  assign gap_a_eff = (cfg_gap_a_i == '0) ? CW'(1) : cfg_gap_a_i;
  assign gap_c_eff = (cfg_gap_c_i == '0) ? CW'(1) : cfg_gap_c_i;
  assign to_eff    = (cfg_ack_to_i == '0) ? CW'(1) : cfg_ack_to_i;

  assign cfg_en = (state_q == ST_SYNC) && ack_i;

  tpat_down_cnt #(.CW(CW)) dur_i (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .ld_i     (ld),
    .ld_val_i (ld_val),
    .zero_o   (cnt_zero)
  );

  tpat_next_chan #(.NCH(NCH), .IW(IW)) scan_i (
    .mask_i      (mask_q),
    .cur_i       (ch_q),
    .first_idx_o (first_idx),
    .first_vld_o (first_vld),
    .next_idx_o  (next_idx),
    .next_vld_o  (next_vld)
  );

  tpat_trig_timer #(.CW(CW)) trg_i (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .start_i (state_q == ST_TSRST),
    .dly1_i  (cfg_trig_dly1_i),
    .dly2_i  (cfg_trig_dly2_i),
    .trig_o  (trig_o),
    .done_o  (trig_done)
  );

  // Next-state logic
  always_comb begin
    state_d = state_q;
    ch_d    = ch_q;
    ch_en   = 1'b0;
    err_d   = err_q;
    ld      = 1'b0;
    ld_val  = '0;
    unique case (state_q)
      ST_IDLE: begin
        if (en_i) begin
          state_d = ST_SYNC;
          ld      = 1'b1;
          ld_val  = to_eff - 1'b1;
        end
      end
      ST_SYNC: begin
        if (ack_i) begin
          state_d = ST_TSRST;
          err_d   = 1'b0;
        end else if (cnt_zero) begin
          state_d = ST_IDLE;
          err_d   = 1'b1;
        end
      end
      ST_TSRST: begin
        if (first_vld) begin
          state_d = ST_A_PLS;
          ch_d    = first_idx;
          ch_en   = 1'b1;
          ld      = 1'b1;
          ld_val  = len_q - 1'b1;
        end else begin
          state_d = ST_DRAIN;
        end
      end
      ST_A_PLS, ST_B_PLS: begin
        if (cnt_zero) begin
          state_d = (state_q == ST_A_PLS) ? ST_A_GAP : ST_B_GAP;
          ld      = 1'b1;
          ld_val  = gap_a_q - 1'b1;
        end
      end
      ST_A_GAP: begin
        if (cnt_zero) begin
          ld     = 1'b1;
          ld_val = len_q - 1'b1;
          if (next_vld) begin
            state_d = ST_A_PLS;
            ch_d    = next_idx;
            ch_en   = 1'b1;
          end else begin
            state_d = ST_B_PLS;
          end
        end
      end
      ST_B_GAP: begin
        if (cnt_zero) begin
          state_d = ST_C_PLS;
          ch_d    = first_idx;
          ch_en   = 1'b1;
          ld      = 1'b1;
          ld_val  = len_q - 1'b1;
        end
      end
      ST_C_PLS: begin
        if (cnt_zero) begin
          state_d = ST_C_GAP;
          ld      = 1'b1;
          ld_val  = gap_c_q - 1'b1;
        end
      end
      ST_C_GAP: begin
        if (cnt_zero) begin
          if (next_vld) begin
            state_d = ST_C_PLS;
            ch_d    = next_idx;
            ch_en   = 1'b1;
            ld      = 1'b1;
            ld_val  = len_q - 1'b1;
          end else begin
            state_d = ST_DRAIN;
          end
        end
      end
      ST_DRAIN: begin
        if (trig_done) begin
          if (en_i) begin
            state_d = ST_SYNC;
            ld      = 1'b1;
            ld_val  = to_eff - 1'b1;
          end else begin
            state_d = ST_IDLE;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // Registers
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      state_q <= ST_IDLE;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      err_q   <= err_d;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      ch_q <= '0;
    end else if (ch_en) begin
      ch_q <= ch_d;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      mask_q  <= '0;
      len_q   <= CW'(MIN_PULSE_CYC);
      gap_a_q <= CW'(1);
      gap_c_q <= CW'(1);
    end else if (cfg_en) begin
      mask_q  <= cfg_mask_i;
      len_q   <= len_eff;
      gap_a_q <= gap_a_eff;
      gap_c_q <= gap_c_eff;
    end
  end

  // Output decode
  always_comb begin
    pulse_o = '0;
    if ((state_q == ST_A_PLS) || (state_q == ST_C_PLS)) begin
      pulse_o[ch_q] = 1'b1;
    end else if (state_q == ST_B_PLS) begin
      pulse_o = mask_q;
    end
  end

  assign sync_req_o = (state_q == ST_SYNC);
  assign ts_rst_o   = (state_q == ST_TSRST);
  assign err_o      = err_q;

endmodule

// File: rtl/tpat_sequencer_chk.sv
`timescale 1ns/1ps
module tpat_sequencer_chk #(
  parameter int NCH           = 32,
  parameter int MIN_PULSE_CYC = 4
) (
  input logic           clk,
  input logic           rst_n,
  input logic [NCH-1:0] pulse,
  input logic [NCH-1:0] mask_q,
  input logic           sync_req,
  input logic           ts_rst,
  input logic           trig,
  input logic           err,
  input logic           ack
);

  logic [15:0] hi_len;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_len <= '0;
    end else if (|pulse) begin
      if (hi_len != 16'hFFFF) hi_len <= hi_len + 1'b1;
    end else begin
      hi_len <= '0;
    end
  end

  // R9
  masked_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pulse & ~mask_q) == '0);

  // R2
  ts_after_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ts_rst |-> $past(sync_req && ack));

  // R2
  ts_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ts_rst |=> !ts_rst);

  // R2
  sync_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sync_req |-> (pulse == '0) && !ts_rst);

  // R8
  trig_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trig |=> !trig);

  // R7
  pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(|pulse) |-> (hi_len >= 16'(MIN_PULSE_CYC)));

  // R3
  err_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err) |-> $past(sync_req));

  // R12
  stray_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !sync_req) |=> !ts_rst);

endmodule

bind tpat_sequencer tpat_sequencer_chk #(
  .NCH(NCH),
  .MIN_PULSE_CYC(MIN_PULSE_CYC)
) chk_i (
  .clk      (clk),
  .rst_n    (rst_sync_n),
  .pulse    (pulse_o),
  .mask_q   (mask_q),
  .sync_req (sync_req_o),
  .ts_rst   (ts_rst_o),
  .trig     (trig_o),
  .err      (err_o),
  .ack      (ack_i)
);

// File: tb/tpat_sequencer_tb_top.sv
`timescale 1ns/1ps
module tpat_sequencer_tb_top;

  localparam int NCH = 32;
  localparam int CW  = 16;
  localparam int NV  = 5;
  localparam int MAXEV = 80;

  localparam logic [31:0] V_MASK [NV] = '{32'h0000F0F0, 32'h80000001, 32'h00000000,
                                          32'hFFFFFFFF, 32'h00000400};
  localparam int V_LEN  [NV] = '{8, 1, 8, 4, 20};
  localparam int V_GA   [NV] = '{20, 5, 5, 3, 10};
  localparam int V_GC   [NV] = '{4, 0, 4, 4, 4};
  localparam int V_D1   [NV] = '{30, 0, 10, 5, 2};
  localparam int V_D2   [NV] = '{200, 0, 15, 400, 3};
  localparam int V_ACKD [NV] = '{0, 3, 1, 5, 2};

  logic clk;
  logic rst_n;
  logic en, ack;
  logic [NCH-1:0] cfg_mask;
  logic [CW-1:0]  cfg_len, cfg_ga, cfg_gc, cfg_d1, cfg_d2, cfg_to;
  logic [NCH-1:0] pulse;
  logic sync_req, ts_rst, trig, err;

  initial clk = 1'b0;
  always #5 clk = ~clk;

  tpat_sequencer #(.NCH(NCH), .CW(CW), .MIN_PULSE_CYC(4)) dut_i (
    .clk             (clk),
    .rst_n           (rst_n),
    .en_i            (en),
    .ack_i           (ack),
    .cfg_mask_i      (cfg_mask),
    .cfg_pulse_len_i (cfg_len),
    .cfg_gap_a_i     (cfg_ga),
    .cfg_gap_c_i     (cfg_gc),
    .cfg_trig_dly1_i (cfg_d1),
    .cfg_trig_dly2_i (cfg_d2),
    .cfg_ack_to_i    (cfg_to),
    .pulse_o         (pulse),
    .sync_req_o      (sync_req),
    .ts_rst_o        (ts_rst),
    .trig_o          (trig),
    .err_o           (err)
  );

  int n_chk, n_fail;
  bit finished;

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Acknowledge responder
  bit ack_en, ack_force;
  int ack_dly, ack_w;
  initial begin
    ack = 1'b0; ack_en = 1'b0; ack_force = 1'b0; ack_dly = 0; ack_w = 0;
  end
  always @(negedge clk) begin
    ack = ack_force;
    if (ack_en && sync_req) begin
      if (ack_w == ack_dly) begin
        ack = 1'b1;
        ack_w = 0;
      end else begin
        ack_w++;
      end
    end else begin
      ack_w = 0;
    end
  end

  // Output monitor
  int cyc, ev_n, ts_n, ts_t, tr_n, hi_cyc, sy_n, sy_hi;
  int ev_t [MAXEV];
  logic [31:0] ev_v [MAXEV];
  int tr_t [4];
  int sy_t [4];
  logic [31:0] prev_pulse;
  logic prev_sync;
  initial begin
    cyc = 0; prev_pulse = '0; prev_sync = 1'b0;
  end

  task automatic clear_mon();
    ev_n = 0; ts_n = 0; ts_t = 0; tr_n = 0; hi_cyc = 0; sy_n = 0; sy_hi = 0;
  endtask

  always @(negedge clk) begin
    cyc++;
    if ((pulse & ~prev_pulse) != '0) begin
      if (ev_n < MAXEV) begin
        ev_t[ev_n] = cyc;
        ev_v[ev_n] = pulse;
      end
      ev_n++;
    end
    if (pulse != '0) hi_cyc++;
    if (ts_rst) begin
      if (ts_n == 0) ts_t = cyc;
      ts_n++;
    end
    if (trig) begin
      if (tr_n < 4) tr_t[tr_n] = cyc;
      tr_n++;
    end
    if (sync_req && !prev_sync) begin
      if (sy_n < 4) sy_t[sy_n] = cyc;
      sy_n++;
    end
    if (sync_req) sy_hi++;
    prev_pulse = pulse;
    prev_sync  = sync_req;
  end

  function automatic int maxi(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  task automatic set_cfg(input int v);
    cfg_mask = V_MASK[v];
    cfg_len  = CW'(V_LEN[v]);
    cfg_ga   = CW'(V_GA[v]);
    cfg_gc   = CW'(V_GC[v]);
    cfg_d1   = CW'(V_D1[v]);
    cfg_d2   = CW'(V_D2[v]);
    ack_dly  = V_ACKD[v];
  endtask

  // Expected end-of-pattern: sync of the next pattern, relative to ts cycle k
  function automatic int next_sync(input int v, input int k);
    int kk, L, pa, pc, e, j;
    kk = 0;
    for (int c = 0; c < NCH; c++) if (V_MASK[v][c]) kk++;
    L  = maxi(V_LEN[v], 4);
    pa = L + maxi(V_GA[v], 1);
    pc = L + maxi(V_GC[v], 1);
    if (kk > 0) e = k + 1 + kk * pa + pa + (kk - 1) * pc + pc - 1;
    else        e = k;
    j = k + 1 + V_D1[v] + maxi(V_D2[v], 2);
    return maxi(e, j) + 2;
  endfunction

  task automatic check_pattern(input int v, input string tg);
    int chl [NCH];
    int kk, L, pa, pc, k, tb, d2c;
    kk = 0;
    for (int c = 0; c < NCH; c++) if (V_MASK[v][c]) begin chl[kk] = c; kk++; end
    L   = maxi(V_LEN[v], 4);
    pa  = L + maxi(V_GA[v], 1);
    pc  = L + maxi(V_GC[v], 1);
    d2c = maxi(V_D2[v], 2);
    k   = ts_t;
    chk({"R9 event count ", tg}, ev_n, (kk > 0) ? 2 * kk + 1 : 0);
    chk({"R7 high cycles ", tg}, hi_cyc, (kk > 0) ? (2 * kk + 1) * L : 0);
    if (ev_n == 2 * kk + 1 && kk > 0) begin
      for (int i = 0; i < kk; i++) begin
        chk({"R4 A start ", tg}, ev_t[i], k + 1 + i * pa);
        chk({"R4 A lines ", tg}, int'(ev_v[i]), int'(32'h1 << chl[i]));
      end
      tb = k + 1 + kk * pa;
      chk({"R5 B start ", tg}, ev_t[kk], tb);
      chk({"R5 B lines ", tg}, int'(ev_v[kk]), int'(V_MASK[v]));
      for (int i = 0; i < kk; i++) begin
        chk({"R6 C start ", tg}, ev_t[kk + 1 + i], tb + pa + i * pc);
        chk({"R6 C lines ", tg}, int'(ev_v[kk + 1 + i]), int'(32'h1 << chl[i]));
      end
    end
    chk({"R8 trig count ", tg}, tr_n, 2);
    if (tr_n >= 2) begin
      chk({"R8 trig first ", tg}, tr_t[0], k + 1 + V_D1[v]);
      chk({"R8 trig second ", tg}, tr_t[1], k + 1 + V_D1[v] + d2c);
    end
  endtask

  // Single pattern with enable dropped while waiting for acknowledge
  task automatic run_vector(input int v);
    string tg;
    tg = $sformatf("vec%0d", v);
    @(negedge clk);
    set_cfg(v);
    clear_mon();
    ack_en = 1'b1;
    en = 1'b1;
    while (!sync_req) @(negedge clk);
    en = 1'b0;
    repeat (1500) @(negedge clk);
    chk({"R2 request cycles ", tg}, sy_hi, V_ACKD[v] + 1);
    chk({"R2 ts count ", tg}, ts_n, 1);
    chk({"R2 ts cycle ", tg}, ts_t, sy_t[0] + V_ACKD[v] + 1);
    check_pattern(v, tg);
    chk({"R11 no restart ", tg}, sy_n, 1);
    chk({"R3 err clear ", tg}, int'(err), 0);
  endtask

  initial begin
    n_chk = 0; n_fail = 0; finished = 1'b0;
    rst_n = 1'b0; en = 1'b0;
    cfg_mask = '0; cfg_len = '0; cfg_ga = '0; cfg_gc = '0;
    cfg_d1 = '0; cfg_d2 = '0; cfg_to = CW'(1000);
    clear_mon();
    repeat (4) @(negedge clk);
    // R1 reset state
    chk("R1 pulse lines", int'(pulse), 0);
    chk("R1 sync_req", int'(sync_req), 0);
    chk("R1 ts_rst", int'(ts_rst), 0);
    chk("R1 trig", int'(trig), 0);
    chk("R1 err", int'(err), 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // Vector table
    for (int v = 0; v < NV; v++) run_vector(v);

    // R3 acknowledge timeout
    @(negedge clk);
    cfg_to = CW'(10);
    ack_en = 1'b0;
    clear_mon();
    en = 1'b1;
    while (!sync_req) @(negedge clk);
    en = 1'b0;
    repeat (40) @(negedge clk);
    chk("R3 request cycles before timeout", sy_hi, 10);
    chk("R3 err set", int'(err), 1);
    chk("R3 no ts after timeout", ts_n, 0);

    // R12 acknowledge outside the handshake
    clear_mon();
    ack_force = 1'b1;
    repeat (5) @(negedge clk);
    ack_force = 1'b0;
    repeat (20) @(negedge clk);
    chk("R12 no ts", ts_n, 0);
    chk("R12 no request", sy_n, 0);
    chk("R12 no pulses", ev_n, 0);
    chk("R12 err kept", int'(err), 1);

    // R3 clear via accepted acknowledge (empty mask pattern)
    cfg_to = CW'(1000);
    run_vector(2);

    // R10 back-to-back patterns with enable held
    @(negedge clk);
    set_cfg(4);
    ack_dly = 0;
    ack_en = 1'b1;
    clear_mon();
    en = 1'b1;
    while (sy_n < 2) @(negedge clk);
    en = 1'b0;
    repeat (300) @(negedge clk);
    chk("R10 second request cycle", sy_t[1], next_sync(4, ts_t));
    chk("R11 stop after second pattern", sy_n, 2);
    chk("R11 second pattern events", ev_n, 6);

    // R10 with empty mask (trigger-bound)
    @(negedge clk);
    set_cfg(2);
    ack_dly = 0;
    clear_mon();
    en = 1'b1;
    while (sy_n < 2) @(negedge clk);
    en = 1'b0;
    repeat (300) @(negedge clk);
    chk("R10 empty mask request cycle", sy_t[1], next_sync(2, ts_t));
    chk("R9 empty mask no pulses", ev_n, 0);
    chk("R8 empty mask triggers", tr_n, 4);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule